// File: doc/BRIEF.md
# Dual Accumulator with Combining and Rounding Output Stage

This block closes the arithmetic path of a two-channel FIR datapath. Each channel delivers one product sum per clock. A per-channel accumulator either folds that sum into a running total or starts a new total from it. A hold register keeps the most recently finished total, and the combiner reads it every clock. The combiner can pass channel A alone, pass channel B alone, add the two channels, or add channel B to channel A after scaling B down by 2^-10. It can then add a single rounding unit at one of twelve programmable weights. The result is a registered word of `W` bits (default 28) that wraps modulo 2^W.

The word carries weights 2^9 down to 2^-18, so bit k has weight 2^(k-18). The caller drives the accumulate enable high for every product after the first product of a sum. A low sample of the enable does two things: it closes the running total into the hold register, and it restarts the accumulator from the product that arrives with it. Both channels use the same controls.

Accumulate control is a two-state machine clocked by the sampled enable:
- RESTART: feedback is zeroed and the hold registers load. It is the reset state.
- SUM: feedback is on and the hold registers keep their value.

Transitions: RESTART stays in RESTART while the enable is low and goes to SUM when it is high. SUM stays in SUM while the enable is high and goes back to RESTART when it is low.

Top module: `fir_acc_combiner`

## Requirements
- R1: During reset and for the first two rising edges after reset is released, `res_out` is 0. Out of reset, rounding is disabled and no total is held.
- R2: A sum covers the products from the sample where `acc_en` was low that started it, through the last sample where `acc_en` was high before the next low sample. The sum is taken modulo 2^W.
- R3: A low `acc_en` sample closes the running total into the hold register. The accumulator then restarts from the product sampled with it, with zero feedback and no earlier products.
- R4: While `acc_en` stays high and the controls are constant, `res_out` does not change, whatever products arrive.
- R5: `cmb_sel` = 2'b00 gives A plus (B shifted right by 10 bits, low bits dropped). The shift is arithmetic when `res_unsigned` = 0 and logical when `res_unsigned` = 1.
- R6: `cmb_sel` = 2'b01 gives A plus B.
- R7: `cmb_sel` = 2'b10 gives A alone, and `cmb_sel` = 2'b11 gives B alone.
- R8: With rounding enabled, codes 0 to 11 of `rnd_code` add 1 at bit (code + 8), which is weight 2^(code-10). Code 0011 adds at bit 11 (weight 2^-7), code 0000 at bit 8, and code 1011 at bit 19.
- R9: Rounding is enabled when `rnd_en_n` = 0. With `rnd_en_n` = 1, and for codes 12 to 15, nothing is added.
- R10: All sums wrap modulo 2^W and never saturate.
- R11: Controls sampled at rising edge n, together with the hold content after edge n+1, determine `res_out` after edge n+2.
- R12: The two channels keep separate totals. A product on one channel never reaches the other channel's total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_a | input | W | Product sum of channel A |
| prod_b | input | W | Product sum of channel B |
| acc_en | input | 1 | 1 = fold the product into the total, 0 = close the total and restart |
| cmb_sel | input | 2 | Combine select: 00 A+B·2^-10, 01 A+B, 10 A, 11 B |
| rnd_code | input | 4 | Rounding weight code, 0..11 valid |
| rnd_en_n | input | 1 | Rounding enable, active low |
| res_unsigned | input | 1 | 1 = operands unsigned (logical scaling shift) |
| res_out | output | W | Registered combined and rounded result |

## Verification
Products and `acc_en` pass through two registers before a total reaches the hold stage. Combine and rounding controls are delayed to match that stage, so the result for an input sampled at edge n appears after edge n+2. The bench feeds each sampled input to a model that tracks the running and closed totals. It holds each expected value in a two-deep delay line and compares it at the falling edge two clocks later. Because the enable, the controls and the products can all change every cycle under random stimulus, these timing relations are tested directly. Directed sequences fix the hold interval, the rounding codes at the edges of the valid range, wrap-around and channel independence.

// File: rtl/fir_acc_pkg.sv
package fir_acc_pkg;

    typedef enum logic [1:0] {
        CMB_A_PLUS_BS = 2'b00,
        CMB_A_PLUS_B  = 2'b01,
        CMB_A_ONLY    = 2'b10,
        CMB_B_ONLY    = 2'b11
    } cmb_sel_e;

    typedef enum logic {
        ACC_RESTART = 1'b0,
        ACC_SUM     = 1'b1
    } acc_state_e;

    typedef struct packed {
        cmb_sel_e   sel;
        logic [3:0] code;
        logic       rnd_n;
        logic       uns;
    } out_ctrl_t;

    localparam out_ctrl_t CTRL_RESET = '{sel: CMB_A_PLUS_BS, code: 4'd0, rnd_n: 1'b1, uns: 1'b0};

endpackage

// File: rtl/acc_mode_fsm.sv
module acc_mode_fsm
    import fir_acc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    output acc_state_e state_q,
    output logic       fb_en,
    output logic       hold_ld
);

    acc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_RESTART: if (acc_en)  state_d = ACC_SUM;
            ACC_SUM:     if (!acc_en) state_d = ACC_RESTART;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_RESTART;
        else        state_q <= state_d;
    end

    always_comb begin
        fb_en   = 1'b0;
        hold_ld = 1'b1;
        unique case (state_q)
            ACC_RESTART: begin fb_en = 1'b0; hold_ld = 1'b1; end
            ACC_SUM:     begin fb_en = 1'b1; hold_ld = 1'b0; end
        endcase
    end

endmodule

// File: rtl/acc_lane.sv
module acc_lane #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prod,
    input  logic         fb_en,
    input  logic         hold_ld,
    output logic [W-1:0] prod_q,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] hold_q
);

    logic [W-1:0] feedback;

    assign feedback = fb_en ? acc_q : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            acc_q  <= '0;
            hold_q <= '0;
        end else begin
            prod_q <= prod;
            acc_q  <= prod_q + feedback;
            if (hold_ld) hold_q <= acc_q;
        end
    end

endmodule

// File: rtl/out_combiner.sv
module out_combiner
    import fir_acc_pkg::*;
#(
    parameter int W        = 28,
    parameter int SHIFT    = 10,
    parameter int RND_BASE = 8,
    parameter int RND_MAX  = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hold_a,
    input  logic [W-1:0] hold_b,
    input  out_ctrl_t    ctrl,
    output logic [W-1:0] res_q
);

    logic [W-1:0] b_scaled;
    logic [W-1:0] mix;
    logic [W-1:0] rnd_add;

    always_comb begin
        if (ctrl.uns) b_scaled = hold_b >> SHIFT;
        else          b_scaled = W'($signed(hold_b) >>> SHIFT);
    end

    always_comb begin
        mix = '0;
        unique case (ctrl.sel)
            CMB_A_PLUS_BS: mix = hold_a + b_scaled;
            CMB_A_PLUS_B:  mix = hold_a + hold_b;
            CMB_A_ONLY:    mix = hold_a;
            CMB_B_ONLY:    mix = hold_b;
        endcase
    end

    always_comb begin
        rnd_add = '0;
        if (!ctrl.rnd_n && (int'(ctrl.code) <= RND_MAX))
            rnd_add = W'(1) << (RND_BASE + int'(ctrl.code));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= mix + rnd_add;
    end

endmodule

// File: rtl/fir_acc_combiner.sv
module fir_acc_combiner
    import fir_acc_pkg::*;
#(
    parameter int W        = 28,
    parameter int SHIFT    = 10,
    parameter int RND_BASE = 8,
    parameter int RND_MAX  = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prod_a,
    input  logic [W-1:0] prod_b,
    input  logic         acc_en,
    input  logic [1:0]   cmb_sel,
    input  logic [3:0]   rnd_code,
    input  logic         rnd_en_n,
    input  logic         res_unsigned,
    output logic [W-1:0] res_out
);

    localparam int LANES = 2;

    acc_state_e   state_q;
    logic         fb_en;
    logic         hold_ld;
    logic [W-1:0] prod_in  [LANES];
    logic [W-1:0] prod_q   [LANES];
    logic [W-1:0] acc_q    [LANES];
    logic [W-1:0] hold_q   [LANES];
    out_ctrl_t    ctrl_in;
    out_ctrl_t    ctrl_s1;
    out_ctrl_t    ctrl_s2;

    assign prod_in[0] = prod_a;
    assign prod_in[1] = prod_b;
    assign ctrl_in    = '{sel: cmb_sel_e'(cmb_sel), code: rnd_code,
                          rnd_n: rnd_en_n, uns: res_unsigned};

    acc_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (acc_en),
        .state_q (state_q),
        .fb_en   (fb_en),
        .hold_ld (hold_ld)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        acc_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .prod    (prod_in[g]),
            .fb_en   (fb_en),
            .hold_ld (hold_ld),
            .prod_q  (prod_q[g]),
            .acc_q   (acc_q[g]),
            .hold_q  (hold_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_s1 <= CTRL_RESET;
            ctrl_s2 <= CTRL_RESET;
        end else begin
            ctrl_s1 <= ctrl_in;
            ctrl_s2 <= ctrl_s1;
        end
    end

    out_combiner #(
        .W(W), .SHIFT(SHIFT), .RND_BASE(RND_BASE), .RND_MAX(RND_MAX)
    ) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_a (hold_q[0]),
        .hold_b (hold_q[1]),
        .ctrl   (ctrl_s2),
        .res_q  (res_out)
    );

endmodule

// File: rtl/fir_acc_combiner_chk.sv
module fir_acc_combiner_chk
    import fir_acc_pkg::*;
#(
    parameter int W = 28
) (
    input logic         clk,
    input logic         rst_n,
    input acc_state_e   state_q,
    input logic [W-1:0] prod_q_a,
    input logic [W-1:0] prod_q_b,
    input logic [W-1:0] acc_a,
    input logic [W-1:0] acc_b,
    input logic [W-1:0] hold_a,
    input logic [W-1:0] hold_b,
    input out_ctrl_t    ctrl,
    input logic [W-1:0] res_out
);

    logic [W-1:0] rnd_unit;
    assign rnd_unit = (int'(ctrl.code) <= 11) ? (W'(1) << (int'(ctrl.code) + 8)) : '0;

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ACC_SUM |=> ($stable(hold_a) && $stable(hold_b)));

    // R3
    restart_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ACC_RESTART |=> acc_a == $past(prod_q_a));

    // R12
    restart_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ACC_RESTART |=> acc_b == $past(prod_q_b));

    // R3
    close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ACC_RESTART |=> hold_a == $past(acc_a));

    // R7
    pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.sel == CMB_A_ONLY && ctrl.rnd_n) |=> res_out == $past(hold_a));

    // R7
    pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.sel == CMB_B_ONLY && ctrl.rnd_n) |=> res_out == $past(hold_b));

    // R6
    add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.sel == CMB_A_PLUS_B && ctrl.rnd_n) |=> res_out == $past(hold_a + hold_b));

    // R8
    round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.sel == CMB_A_ONLY && !ctrl.rnd_n) |=> res_out == $past(hold_a + rnd_unit));

endmodule

bind fir_acc_combiner fir_acc_combiner_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .prod_q_a (prod_q[0]),
    .prod_q_b (prod_q[1]),
    .acc_a    (acc_q[0]),
    .acc_b    (acc_q[1]),
    .hold_a   (hold_q[0]),
    .hold_b   (hold_q[1]),
    .ctrl     (ctrl_s2),
    .res_out  (res_out)
);

// File: tb/fir_acc_combiner_tb.sv
module fir_acc_combiner_tb;

    localparam int W = 28;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] prod_a = '0;
    logic [W-1:0] prod_b = '0;
    logic         acc_en = 1'b0;
    logic [1:0]   cmb_sel = 2'b00;
    logic [3:0]   rnd_code = 4'd0;
    logic         rnd_en_n = 1'b1;
    logic         res_unsigned = 1'b0;
    logic [W-1:0] res_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] run_a = '0, run_b = '0, shut_a = '0, shut_b = '0;
    logic [W-1:0] d1 = '0, d2 = '0, exp_now = '0;
    string        last_tag = "R1";

    always #10 clk = ~clk;

    fir_acc_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .prod_a(prod_a), .prod_b(prod_b),
        .acc_en(acc_en), .cmb_sel(cmb_sel), .rnd_code(rnd_code),
        .rnd_en_n(rnd_en_n), .res_unsigned(res_unsigned), .res_out(res_out)
    );

    function automatic logic [W-1:0] ref_out(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic [1:0] sel, input logic [3:0] code,
                                              input logic rn, input logic un);
        logic [W-1:0] bs, s;
        bs = un ? (b >> 10) : W'($signed(b) >>> 10);
        case (sel)
            2'b00:   s = a + bs;
            2'b01:   s = a + b;
            2'b10:   s = a;
            default: s = b;
        endcase
        if (!rn && code <= 4'd11) s = s + (W'(1) << (code + 8));
        return s;
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: res_out=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic step(input logic [W-1:0] pa, input logic [W-1:0] pb, input logic en,
                        input logic [1:0] sel, input logic [3:0] code, input logic rn,
                        input logic un, input string tag);
        @(negedge clk);
        check(res_out, exp_now, last_tag);
        prod_a = pa; prod_b = pb; acc_en = en; cmb_sel = sel;
        rnd_code = code; rnd_en_n = rn; res_unsigned = un;
        @(posedge clk);
        #1;
        if (en) begin
            run_a = run_a + pa; run_b = run_b + pb;
        end else begin
            shut_a = run_a; shut_b = run_b; run_a = pa; run_b = pb;
        end
        exp_now = d2; d2 = d1;
        d1 = ref_out(shut_a, shut_b, sel, code, rn, un);
        last_tag = tag;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        report();
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(res_out, '0, "R1");
        rst_n = 1'b1;
        // R1: first edges after release still read 0
        step(28'd3, 28'd4, 0, 2'b10, 4'd0, 0, 0, "R1");
        step(28'd5, 28'd6, 0, 2'b10, 4'd0, 1, 0, "R1");
        // R3: restart each cycle, pure pipeline
        for (int i = 0; i < 4; i++) step(W'(i * 11 + 1), W'(i + 100), 0, 2'b10, 4'd0, 1, 0, "R3");
        // R2: run of 5 + 7 + 9 closed by low sample
        step(28'd5, 28'd50, 0, 2'b10, 4'd0, 1, 0, "R2");
        step(28'd7, 28'd70, 1, 2'b10, 4'd0, 1, 0, "R2");
        step(28'd9, 28'd90, 1, 2'b10, 4'd0, 1, 0, "R2");
        step(28'd1, 28'd2, 0, 2'b10, 4'd0, 1, 0, "R2");
        // R4: long high interval with large products, output must stay
        for (int i = 0; i < 6; i++) step(28'h0ABCDEF, 28'h0123456, 1, 2'b01, 4'd0, 1, 0, "R4");
        step(28'd0, 28'd0, 0, 2'b01, 4'd0, 1, 0, "R4");
        // R12: channels distinct, read A then B
        step(28'h0000111, 28'h0777000, 0, 2'b10, 4'd0, 1, 0, "R12");
        step(28'h0000222, 28'h0888000, 1, 2'b11, 4'd0, 1, 0, "R12");
        step(28'd0, 28'd0, 0, 2'b10, 4'd0, 1, 0, "R12");
        step(28'd0, 28'd0, 0, 2'b11, 4'd0, 1, 0, "R12");
        // R5: negative B scaled, signed then unsigned
        step(28'h0000100, 28'hFFF8000, 0, 2'b00, 4'd0, 1, 0, "R5");
        step(28'h0000100, 28'hFFF8000, 0, 2'b00, 4'd0, 1, 0, "R5");
        step(28'h0000100, 28'hFFF8000, 0, 2'b00, 4'd0, 1, 1, "R5");
        step(28'h0000100, 28'hFFF8000, 0, 2'b00, 4'd0, 1, 1, "R5");
        // R6 / R7
        step(28'h0001000, 28'h0000020, 0, 2'b01, 4'd0, 1, 0, "R6");
        step(28'h0001000, 28'h0000020, 0, 2'b10, 4'd0, 1, 0, "R7");
        step(28'h0001000, 28'h0000020, 0, 2'b11, 4'd0, 1, 0, "R7");
        // R8: codes 3, 0, 11
        step(28'd0, 28'd0, 0, 2'b10, 4'd3, 0, 0, "R8");
        step(28'd0, 28'd0, 0, 2'b10, 4'd0, 0, 0, "R8");
        step(28'd0, 28'd0, 0, 2'b10, 4'd11, 0, 0, "R8");
        // R9: disabled, and out-of-range codes
        step(28'd0, 28'd0, 0, 2'b10, 4'd3, 1, 0, "R9");
        step(28'd0, 28'd0, 0, 2'b10, 4'd12, 0, 0, "R9");
        step(28'd0, 28'd0, 0, 2'b10, 4'd15, 0, 0, "R9");
        // R10: wrap of accumulation and of combine
        step(28'hFFFFFF0, 28'h8000000, 0, 2'b01, 4'd11, 0, 0, "R10");
        step(28'h0000020, 28'h8000000, 1, 2'b01, 4'd11, 0, 0, "R10");
        step(28'd0, 28'd0, 0, 2'b01, 4'd11, 0, 0, "R10");
        // R11: controls change while totals fixed
        step(28'd0, 28'd0, 1, 2'b10, 4'd5, 1, 0, "R11");
        step(28'd0, 28'd0, 1, 2'b11, 4'd5, 0, 0, "R11");
        step(28'd0, 28'd0, 1, 2'b00, 4'd1, 0, 0, "R11");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic en_r;
            en_r = ($urandom % 4) != 0;
            step(W'($urandom), W'($urandom), en_r, 2'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), "R2 R5 R6 R7 R8 R11");
        end
        step(28'd0, 28'd0, 0, 2'b10, 4'd0, 1, 0, "R2");
        step(28'd0, 28'd0, 0, 2'b10, 4'd0, 1, 0, "R2");
        step(28'd0, 28'd0, 0, 2'b10, 4'd0, 1, 0, "R2");
        report();
    end

endmodule